// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Mode Register

This block is an unsigned 32x32 multiplier that sits beside a small processor and is driven from two of its registers. The two operand inputs carry the current contents of those registers. A full 64-bit result is presented as a low word and a high word. A separate 64-bit accumulator lies behind them and is not visible on its own.

A mode register selects how the unit runs. With the mode bit cleared, the unit multiplies on every clock and keeps the accumulator at zero. With the mode bit set, the operands are sampled only when the mode register is written. On each such write their product is added into the accumulator, and the new total appears on the product words. A carry flag in the mode register records that the 64-bit total wrapped. Software clears the flag by writing a 1 to it, and that same write zeroes the accumulator before the addition. The mode register is written through a byte-enabled port and reads back in full.

Top module: `mac_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the mode register, the product words and the accumulator.
- R2: With mode bit 0 clear and no write, every rising edge loads the product words with the full 64-bit unsigned product of `opa` and `opb` as present at that edge. The low half goes to `prod_lo` and the high half to `prod_hi`.
- R3: While mode bit 0 is clear, the accumulator is held at zero. The first accumulation after entering accumulate mode therefore yields the bare product.
- R4: With mode bit 0 set after the write (bit 0 of the mode register, updated through byte lane 0), each write adds `opa*opb` to the accumulator, and the sum appears on the product words at the same edge.
- R5: In accumulate mode, clocks without a write leave the product words unchanged whatever the operands do.
- R6: If an accumulation wraps past 2^64 (new total below the old total), the carry flag (mode bit 1) becomes 1. A flag that is already set stays set.
- R7: A write with byte enable 0 set and data bit 1 set, while the carry flag is 1, clears the flag. It also zeroes the accumulator before that write's own addition.
- R8: Writing data bit 1 as 1 while the flag is 0 leaves it 0. Writing data bit 1 as 0 leaves a set flag set.
- R9: Each byte of the mode register changes only when its byte enable is set during a write. A write with byte enable 0 clear still triggers accumulation when the unit is in accumulate mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the mode register |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data for the mode register |
| opa | input | 32 | First operand (processor register contents) |
| opb | input | 32 | Second operand (processor register contents) |
| mode_rd | output | 32 | Mode register read-back; bit 0 accumulate mode, bit 1 carry flag |
| prod_lo | output | 32 | Low word of product or accumulated sum |
| prod_hi | output | 32 | High word of product or accumulated sum |

## Verification
Two functions can land on the same write edge: clearing the carry flag together with its accumulator zeroing, and the accumulation that the same write triggers. The bench provokes this by first wrapping the accumulator with repeated maximum operands. It then issues one write with byte 0 set to 3 and small operands. The outcome must be a clear flag and a sum equal to the bare product, not the old total plus the product. A mode switch into accumulate mode coinciding with the first addition is provoked the same way. Both are judged by the explicit expected values and by the behavioural model compared at every falling edge.

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int OPW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OPW/8-1:0] wr_be,
  input  logic [OPW-1:0]   wr_data,
  input  logic [OPW-1:0]   opa,
  input  logic [OPW-1:0]   opb,
  output logic [OPW-1:0]   mode_rd,
  output logic [OPW-1:0]   prod_lo,
  output logic [OPW-1:0]   prod_hi
);
  localparam int PW    = 2 * OPW;
  localparam int LANES = OPW / 8;
  localparam int B_ACC = 0;
  localparam int B_CRY = 1;

  logic [OPW-1:0] mode_q, mode_wr;
  logic [PW-1:0]  prod_q, acc_q, prod_in, base;
  logic [PW:0]    sum_ext;
  logic           acc_sel, clr, carry_nx, upd;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign mode_wr[8*k +: 8] = wr_be[k] ? wr_data[8*k +: 8] : mode_q[8*k +: 8];
  end

  assign prod_in  = {{OPW{1'b0}}, opa} * {{OPW{1'b0}}, opb};
  assign acc_sel  = wr_en ? mode_wr[B_ACC] : mode_q[B_ACC];
  assign clr      = wr_en & wr_be[0] & wr_data[B_CRY] & mode_q[B_CRY];
  assign base     = clr ? '0 : acc_q;
  assign sum_ext  = {1'b0, base} + {1'b0, prod_in};
  assign carry_nx = (mode_q[B_CRY] & ~clr) | (acc_sel & sum_ext[PW]);
  assign upd      = wr_en | ~mode_q[B_ACC];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      prod_q <= '0;
      acc_q  <= '0;
    end else begin
      if (wr_en)
        mode_q <= {mode_wr[OPW-1:2], carry_nx, mode_wr[B_ACC]};
      if (upd) begin
        if (acc_sel) begin
          prod_q <= sum_ext[PW-1:0];
          acc_q  <= sum_ext[PW-1:0];
        end else begin
          prod_q <= prod_in;
          acc_q  <= '0;
        end
      end
    end
  end

  assign mode_rd = mode_q;
  assign prod_lo = prod_q[OPW-1:0];
  assign prod_hi = prod_q[PW-1:OPW];

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (mode_q == '0 && prod_q == '0 && acc_q == '0));

  p_mul_acc_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode_q[B_ACC] && !wr_en) |=> (acc_q == '0));

  p_hold_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q[B_ACC] && !wr_en) |=> $stable(prod_q));

  p_carry_write_only_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mode_q));

  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_be[0] && wr_data[B_CRY] && mode_q[B_CRY]) |=> !mode_q[B_CRY]);

  p_no_set_by_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mode_q[B_CRY] && !(acc_sel && sum_ext[PW])) |=> !mode_q[B_CRY]);

  p_lane0_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_be[0]) |=> (mode_q[B_ACC] == $past(mode_q[B_ACC])));
endmodule

// File: tb/mac_unit_bench.sv
module mac_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0, opa = '0, opb = '0;
  logic [31:0] mode_rd, prod_lo, prod_hi;

  int tests = 0, fails = 0;
  bit chk_on = 1'b0;
  string phase = "R1";

  logic [31:0] m_mode;
  logic [63:0] m_prod, m_acc;

  always #2.5 clk = ~clk;

  mac_unit u_mac_unit (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .opa(opa), .opb(opb), .mode_rd(mode_rd),
    .prod_lo(prod_lo), .prod_hi(prod_hi));

  always @(posedge clk) begin
    logic [63:0] p, old, s;
    logic [31:0] nm;
    bit clr, cy;
    if (rst) begin
      m_mode <= '0; m_prod <= '0; m_acc <= '0;
    end else begin
      p = {32'b0, opa} * {32'b0, opb};
      if (wr_en) begin
        nm = m_mode;
        for (int k = 0; k < 4; k++) if (wr_be[k]) nm[8*k +: 8] = wr_data[8*k +: 8];
        clr = wr_be[0] && wr_data[1] && m_mode[1];
        cy = m_mode[1] && !clr;
        if (nm[0]) begin
          old = clr ? 64'd0 : m_acc;
          s = old + p;
          if (s < old) cy = 1'b1;
          m_prod <= s; m_acc <= s;
        end else begin
          m_prod <= p; m_acc <= '0;
        end
        nm[1] = cy;
        m_mode <= nm;
      end else if (!m_mode[0]) begin
        m_prod <= p; m_acc <= '0;
      end
    end
  end

  always @(negedge clk) if (chk_on) begin
    tests++;
    if ({prod_hi, prod_lo} !== m_prod || mode_rd !== m_mode) begin
      fails++;
      $display("FAIL %s model: prod=%h mode=%h expected prod=%h mode=%h",
               phase, {prod_hi, prod_lo}, mode_rd, m_prod, m_mode);
    end
  end

  task automatic step(input logic [31:0] a, input logic [31:0] b,
                      input bit en, input logic [3:0] be, input logic [31:0] d);
    opa = a; opb = b; wr_en = en; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_val(input string req, input logic [63:0] ep, input logic [31:0] em);
    tests++;
    if ({prod_hi, prod_lo} !== ep || mode_rd !== em) begin
      fails++;
      $display("FAIL %s: prod=%h mode=%h expected prod=%h mode=%h",
               req, {prod_hi, prod_lo}, mode_rd, ep, em);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_val("R1 reset", 64'd0, 32'd0);
    chk_on = 1'b1;

    phase = "R2";
    step(32'd3, 32'd5, 0, 4'h0, 0);
    expect_val("R2 product", 64'd15, 32'd0);
    step(32'hFFFFFFFF, 32'hFFFFFFFF, 0, 4'h0, 0);
    expect_val("R2 max product", 64'hFFFFFFFE_00000001, 32'd0);
    for (int i = 0; i < 20; i++) step($urandom, $urandom, 0, 4'h0, 0);

    phase = "R3";
    step(32'd7, 32'd9, 1, 4'h1, 32'h1);
    expect_val("R3 R4 enter accumulate", 64'd63, 32'h1);
    phase = "R4";
    step(32'd2, 32'd10, 1, 4'h1, 32'h1);
    expect_val("R4 accumulate", 64'd83, 32'h1);

    phase = "R5";
    for (int i = 0; i < 3; i++) step(32'd100 + i, 32'd100, 0, 4'h0, 0);
    expect_val("R5 hold", 64'd83, 32'h1);

    phase = "R9";
    step(32'd1, 32'd1, 1, 4'hE, 32'hABCDEF00);
    expect_val("R9 upper lanes", 64'd84, 32'hABCDEF01);

    phase = "R6";
    step(32'hFFFFFFFF, 32'hFFFFFFFF, 1, 4'h1, 32'h1);
    expect_val("R6 no wrap", 64'hFFFFFFFE_00000055, 32'hABCDEF01);
    step(32'hFFFFFFFF, 32'hFFFFFFFF, 1, 4'h1, 32'h1);
    expect_val("R6 wrap sets carry", 64'hFFFFFFFC_00000056, 32'hABCDEF03);

    phase = "R8";
    step(32'd0, 32'd0, 1, 4'h1, 32'h1);
    expect_val("R8 zero keeps carry", 64'hFFFFFFFC_00000056, 32'hABCDEF03);
    step(32'd5, 32'd5, 1, 4'hE, 32'hABCDEF02);
    expect_val("R8 R9 lane0 off keeps carry", 64'hFFFFFFFC_0000006F, 32'hABCDEF03);

    phase = "R7";
    step(32'd4, 32'd4, 1, 4'h1, 32'h3);
    expect_val("R7 clear and restart", 64'd16, 32'hABCDEF01);

    phase = "R8";
    step(32'd1, 32'd2, 1, 4'h1, 32'h3);
    expect_val("R8 one does not set", 64'd18, 32'hABCDEF01);

    phase = "R2";
    step(32'd6, 32'd7, 1, 4'h1, 32'h0);
    expect_val("R2 back to multiply", 64'd42, 32'hABCDEF00);
    step(32'd5, 32'd5, 0, 4'h0, 0);
    expect_val("R2 continuous", 64'd25, 32'hABCDEF00);

    phase = "R3";
    step(32'd2, 32'd3, 1, 4'h1, 32'h1);
    expect_val("R3 accumulator zeroed", 64'd6, 32'hABCDEF01);

    phase = "R9";
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r = $urandom;
      step((r[3:0] == 0) ? 32'hFFFFFFFF : $urandom, $urandom, r[4] & r[5],
           r[9:6], {$urandom_range(255, 0), 16'h0, 6'h0, r[11:10]});
    end

    phase = "R1";
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expect_val("R1 reset again", 64'd0, 32'd0);
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule